// File: doc/BRIEF.md
# E1 CRC-4 Submultiframe Checker

This block checks the CRC-4 protection of an E1 receive bit stream that an upstream synchronizer has already aligned to frame and multiframe. Every accepted bit enters a four-bit polynomial remainder that restarts at each submultiframe. The remainder that a finished submultiframe leaves behind becomes the reference for the next submultiframe. The next submultiframe carries the four check bits the far end computed. The block compares the two, raises a one-cycle error pulse when they differ, and counts such submultiframes in a saturating counter.

The synchronizer supplies the position of every bit: its index in the frame, the frame index in the submultiframe, and a start marker. It also supplies a flag that says whether alignment holds. Configuration gives an enable bit and a flag that says whether the CRC multiframe format is selected. The check runs only when both are set. When alignment drops, or the check is switched off, all partial work is discarded and the check starts again cleanly at the next submultiframe start.

Top module: `crc4_smf_checker`

## Requirements
- R1: Checking is active only while `crc_en` and `crc_mf_mode` are both 1. While it is inactive no bit is taken, no pulse is raised and the counter does not change. A submultiframe that is not fully active serves as no reference for the one that follows it.
- R2: The check remainder uses x^4 + x + 1 over all 2048 bits of a submultiframe (8 frames of 256 bits), taken in arrival order. The remainder starts from zero at each submultiframe start. The check-bit positions are treated as zero. These positions are bit index 0 of frames 0, 2, 4 and 6. The remainder's x^3 coefficient is the first check bit.
- R3: The received check bits are read from bit index 0 of frames 0, 2, 4 and 6 of the following submultiframe, first check bit in frame 0. They are compared with the stored remainder. On any difference `smf_err` is 1 for exactly one cycle, the cycle after the frame-6 check bit is accepted, and it is 0 at all other times.
- R4: Each mismatching submultiframe raises `err_count` by exactly one, in the same cycle as the pulse.
- R5: `err_count` is CNT_W bits wide (16 by default) and holds at all ones instead of wrapping.
- R6: `cnt_clr` clears the counter synchronously. When it coincides with a mismatch, the counter becomes 1.
- R7: Any cycle with `sync_ok` at 0 cancels the pending comparison in the current submultiframe. That submultiframe then gives no reference, and checking resumes with the remainder built from the next start marker.
- R8: Cycles with `bit_vld` at 0 are ignored, whatever `bit_in` and `smf_start` carry.
- R9: The first submultiframe after reset has no reference, so it cannot raise an error.
- R10: Reset leaves `err_count` at 0 and `smf_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_vld | input | 1 | Qualifies `bit_in` and the position inputs |
| bit_in | input | 1 | Received serial data bit |
| bit_idx | input | $clog2(BITS_PER_FRAME) | Bit position in the frame, 0 first |
| frm_idx | input | $clog2(FRAMES_PER_SMF) | Frame position in the submultiframe |
| smf_start | input | 1 | Marks the first bit of a submultiframe |
| crc_en | input | 1 | Check enable from configuration |
| crc_mf_mode | input | 1 | 1 when the CRC multiframe format is selected |
| sync_ok | input | 1 | 1 while frame and multiframe alignment holds |
| cnt_clr | input | 1 | Synchronous counter clear |
| err_count | output | CNT_W | Saturating count of failed submultiframes |
| smf_err | output | 1 | One-cycle pulse per failed submultiframe |

## Verification
The counter clear and a counted mismatch can fall on the same edge. To provoke this, one table entry raises `cnt_clr` exactly while the corrupted frame-6 check bit is presented. The bench then expects the counter to read 1, not 0 and not the old value plus one, on both the 16-bit instance and a 2-bit instance. The second overlap is the handover at each submultiframe start: in one cycle the finished remainder is stored and the first bit of the new submultiframe enters a cleared register. Corrupted check bits followed by a clean submultiframe show that the handover and the C-bit zeroing neither lose nor leak a bit.

// File: rtl/crc4_chk_pkg.sv
package crc4_chk_pkg;

  localparam int          CRC_W     = 4;
  localparam logic [3:0]  CRC4_TAPS = 4'b0011; // x + 1 terms of x^4 + x + 1

  // One serial step of the division of M(x)*x^4 by the generator.
  function automatic logic [CRC_W-1:0] crc4_step(input logic [CRC_W-1:0] rem,
                                                 input logic             din);
    logic fb;
    fb = din ^ rem[CRC_W-1];
    return {rem[CRC_W-2:0], 1'b0} ^ (fb ? CRC4_TAPS : '0);
  endfunction

endpackage

// File: rtl/crc4_smf_gen.sv
module crc4_smf_gen
  import crc4_chk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic             din,
  output logic [CRC_W-1:0] crc_q
);

  logic [CRC_W-1:0] base;

  assign base = restart ? '0 : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '0;
    else if (step) crc_q <= crc4_step(base, din);
  end

  AST_REM_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(crc_q)); // R8

endmodule

// File: rtl/crc4_cbit_grab.sv
module crc4_cbit_grab
  import crc4_chk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             din,
  output logic [CRC_W-1:0] word_now
);

  logic [CRC_W-2:0] sh_q;

  // Earlier check bits sit in the upper positions, the bit on the line now is last.
  assign word_now = {sh_q, din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (take) sh_q <= word_now[CRC_W-2:0];
  end

  AST_CBITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(sh_q)); // R3

endmodule

// File: rtl/crc4_sat_cnt.sv
module crc4_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         at_top;
  logic [W-1:0] cnt_nxt;

  assign at_top = (cnt == TOP);

  always_comb begin
    if (clr)                  cnt_nxt = inc ? W'(1) : '0;
    else if (inc && !at_top)  cnt_nxt = cnt + W'(1);
    else                      cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && !at_top) |=> (cnt == $past(cnt) + W'(1))); // R4
  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !clr) |=> (cnt == TOP)); // R5
  AST_CLR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == W'($past(inc)))); // R6

endmodule

// File: rtl/crc4_smf_checker.sv
module crc4_smf_checker
  import crc4_chk_pkg::*;
#(
  parameter  int BITS_PER_FRAME = 256,
  parameter  int FRAMES_PER_SMF = 8,
  parameter  int CNT_W          = 16,
  localparam int BIT_W          = $clog2(BITS_PER_FRAME),
  localparam int FRM_W          = $clog2(FRAMES_PER_SMF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic [FRM_W-1:0] frm_idx,
  input  logic             smf_start,
  input  logic             crc_en,
  input  logic             crc_mf_mode,
  input  logic             sync_ok,
  input  logic             cnt_clr,
  output logic [CNT_W-1:0] err_count,
  output logic             smf_err
);

  localparam logic [FRM_W-1:0] LAST_C_FRM = FRM_W'(FRAMES_PER_SMF - 2);

  // Named events shared by the logic and the assertions.
  logic             active;     // configuration allows checking
  logic             take_bit;   // a bit is accepted this cycle
  logic             smf_go;     // accepted bit opens a submultiframe
  logic             at_cpos;    // accepted position holds a check bit
  logic             at_clast;   // position of the final check bit
  logic             crc_din;    // data seen by the remainder
  logic [CRC_W-1:0] crc_now;    // running remainder
  logic [CRC_W-1:0] rx_cword;   // received check bits incl. current one
  logic [CRC_W-1:0] exp_crc;    // remainder of the previous submultiframe
  logic             exp_vld;    // reference is usable
  logic             cur_clean;  // current submultiframe is intact so far
  logic             mism;       // a counted mismatch this cycle

  assign active   = crc_en & crc_mf_mode;
  assign take_bit = bit_vld & active;
  assign smf_go   = take_bit & smf_start;
  assign at_cpos  = (bit_idx == '0) & ~frm_idx[0];
  assign at_clast = at_cpos & (frm_idx == LAST_C_FRM);
  assign crc_din  = at_cpos ? 1'b0 : bit_in;

  crc4_smf_gen u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (take_bit),
    .restart (smf_start),
    .din     (crc_din),
    .crc_q   (crc_now)
  );

  crc4_cbit_grab u_grab (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take_bit & at_cpos),
    .din      (bit_in),
    .word_now (rx_cword)
  );

  assign mism = take_bit & at_clast & exp_vld & sync_ok & (rx_cword != exp_crc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_clean <= 1'b0;
      exp_vld   <= 1'b0;
      exp_crc   <= '0;
      smf_err   <= 1'b0;
    end else begin
      smf_err <= mism;
      if (!active || !sync_ok) begin
        cur_clean <= 1'b0;
        exp_vld   <= 1'b0;
      end else if (smf_go) begin
        exp_vld   <= cur_clean;
        exp_crc   <= crc_now;
        cur_clean <= 1'b1;
      end
    end
  end

  crc4_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (mism),
    .cnt   (err_count)
  );

  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !smf_err); // R1
  AST_PULSE_AFTER_LAST_C: assert property (@(posedge clk) disable iff (!rst_n)
    smf_err |-> $past(take_bit && at_clast)); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    smf_err |=> !smf_err); // R3
  AST_SYNC_LOSS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ok |=> !smf_err); // R7
  AST_REF_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exp_vld) |-> $past(smf_go)); // R9

endmodule

// File: tb/tb_crc4_smf_checker.sv
module tb_crc4_smf_checker;

  localparam int BPF      = 256;
  localparam int FPS      = 8;
  localparam int SMF_BITS = BPF * FPS;

  typedef struct packed {
    logic [15:0] seed;
    logic [3:0]  mask;   // xor applied to the correct check bits
    logic        en;
    logic        mode;
    logic        drop;   // sync_ok low through frame 3
    logic        gap;    // idle cycles between bits
    logic        clr;    // cnt_clr together with the frame-6 check bit
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [0:NV-1] = '{
    '{16'hA1B2, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'h3C4D, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'h5E6F, 4'h8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'h7081, 4'h1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{16'h92A3, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'hB4C5, 4'h6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{16'hD6E7, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'hF809, 4'h2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'h1A2B, 4'h4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'h3C4E, 4'h1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'h5E60, 4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h7F80, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'h9102, 4'h5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'hA3B4, 4'h9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{16'hC5D6, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'hE7F8, 4'h7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_vld, bit_in, smf_start, crc_en, crc_mf_mode, sync_ok, cnt_clr;
  logic [7:0] bit_idx;
  logic [2:0] frm_idx;
  logic [15:0] err_count;
  logic        smf_err;
  logic [1:0]  sat_count;
  logic        sat_err;

  always #2 clk = ~clk; // 250 MHz

  crc4_smf_checker dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .bit_idx(bit_idx), .frm_idx(frm_idx), .smf_start(smf_start),
    .crc_en(crc_en), .crc_mf_mode(crc_mf_mode), .sync_ok(sync_ok),
    .cnt_clr(cnt_clr), .err_count(err_count), .smf_err(smf_err)
  );

  crc4_smf_checker #(.CNT_W(2)) dut_sat (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .bit_idx(bit_idx), .frm_idx(frm_idx), .smf_start(smf_start),
    .crc_en(crc_en), .crc_mf_mode(crc_mf_mode), .sync_ok(sync_ok),
    .cnt_clr(cnt_clr), .err_count(sat_count), .smf_err(sat_err)
  );

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  logic pay [0:SMF_BITS-1];
  logic [3:0]  prev_crc;
  bit          prev_clean;
  logic [15:0] cnt_m;
  logic [1:0]  sat_m;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_cpos(input int i);
    return ((i % BPF) == 0) && (((i / BPF) % 2) == 0);
  endfunction

  // Long division of the message times x^4 by 10011; remainder msb first.
  function automatic logic [3:0] div_rem();
    logic m [0:SMF_BITS+3];
    for (int i = 0; i < SMF_BITS; i++) m[i] = pay[i];
    for (int i = SMF_BITS; i < SMF_BITS + 4; i++) m[i] = 1'b0;
    for (int i = 0; i < SMF_BITS; i++) begin
      if (m[i]) begin
        m[i]   = 1'b0;
        m[i+3] = ~m[i+3];
        m[i+4] = ~m[i+4];
      end
    end
    return {m[SMF_BITS], m[SMF_BITS+1], m[SMF_BITS+2], m[SMF_BITS+3]};
  endfunction

  task automatic run_smf(input vec_t v, input int k);
    logic [15:0] lf;
    logic [3:0]  this_crc, cword;
    bit          clean, exp_err;
    int          spur;
    lf = v.seed;
    for (int i = 0; i < SMF_BITS; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pay[i] = is_cpos(i) ? 1'b0 : lf[0];
    end
    this_crc = div_rem();                 // R2: C positions counted as zero
    cword    = prev_crc ^ v.mask;
    clean    = v.en && v.mode && !v.drop;
    exp_err  = prev_clean && clean && (v.mask != 4'h0);
    spur     = 0;
    for (int i = 0; i < SMF_BITS; i++) begin
      int  f, b;
      bit  c4;
      f  = i / BPF;
      b  = i % BPF;
      c4 = (f == 6) && (b == 0);
      bit_vld     = 1'b1;
      bit_in      = is_cpos(i) ? cword[3 - f/2] : pay[i];
      bit_idx     = 8'(b);
      frm_idx     = 3'(f);
      smf_start   = (i == 0);
      crc_en      = v.en;
      crc_mf_mode = v.mode;
      sync_ok     = !(v.drop && f == 3);
      cnt_clr     = v.clr && c4;
      @(negedge clk);
      if (c4) begin
        if (v.clr) begin
          cnt_m = exp_err ? 16'd1 : 16'd0;
          sat_m = exp_err ? 2'd1 : 2'd0;
        end else if (exp_err) begin
          if (cnt_m != 16'hFFFF) cnt_m++;
          if (sat_m != 2'd3) sat_m++;
        end
        check(v.clr ? "R6" : (v.drop ? "R7" : (!clean ? "R1" : "R3")),
              $sformatf("smf %0d pulse", k), 32'(smf_err), 32'(exp_err));
        check(v.clr ? "R6" : "R4", $sformatf("smf %0d count", k),
              32'(err_count), 32'(cnt_m));
        check(v.clr ? "R6" : "R5", $sformatf("smf %0d narrow count", k),
              32'(sat_count), 32'(sat_m));
      end else if (smf_err || sat_err) spur++;
      cnt_clr = 1'b0;
      if (v.gap && (i % 5 == 2)) begin  // R8: idle cycle with junk on the inputs
        bit_vld   = 1'b0;
        bit_in    = ~bit_in;
        smf_start = 1'b1;
        @(negedge clk);
        smf_start = 1'b0;
        if (smf_err || sat_err) spur++;
      end
    end
    check(v.gap ? "R8" : "R3", $sformatf("smf %0d stray pulses", k), 32'(spur), 32'd0);
    prev_crc   = this_crc;
    prev_clean = clean;
  endtask

  initial begin
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; bit_idx = '0; frm_idx = '0;
    smf_start = 1'b0; crc_en = 1'b0; crc_mf_mode = 1'b0; sync_ok = 1'b0; cnt_clr = 1'b0;
    prev_crc = 4'h0; prev_clean = 1'b0; cnt_m = '0; sat_m = '0;
    repeat (4) @(negedge clk);
    check("R10", "reset count", 32'(err_count), 32'd0);
    check("R10", "reset pulse", 32'(smf_err), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) run_smf(VEC[k], k);

    // R6: clear alone while idle
    bit_vld = 1'b0; cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0; cnt_m = '0; sat_m = '0;
    check("R6", "clear alone", 32'(err_count), 32'd0);
    check("R6", "clear alone narrow", 32'(sat_count), 32'd0);

    run_smf('{16'h1357, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, 100);
    run_smf('{16'h2468, 4'h2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, 101);

    // R10: reset while running
    bit_vld = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check("R10", "count after reset", 32'(err_count), 32'd0);
    check("R10", "pulse after reset", 32'(smf_err), 32'd0);
    rst_n = 1'b1; cnt_m = '0; sat_m = '0; prev_clean = 1'b0;
    @(negedge clk);

    // R9: corrupted check bits in the first submultiframe after reset
    run_smf('{16'hBEEF, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, 200);
    run_smf('{16'hCAFE, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, 201);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule